// File: doc/BRIEF.md
# PCIe Controller Glue Register Block

This block is the register file that sits on an APB port beside a PCIe controller core. Software uses it to set the core's operating mode and to release the core from reset. It also starts and stops link training, sets up the PHY and the reference-clock PLL, and takes in the controller's interrupt events. The block drives static control outputs into the core, the PHY and the PLL. It samples their lock and link flags and reports them live on read.

Event inputs from the controller set sticky status bits on a rising edge: one bit for MSI and one for each DMA channel. Software clears a status bit by writing a 1 to it. A separate enable register masks the status bits, and the single level interrupt output is high while any enabled status bit is set. The link is reported as up only when both the physical-layer flag and the data-link-layer flag are high.

Top module: `pcie_glue_regs`

## Requirements
- R1: After reset, every writable field, every status bit, every control output and the interrupt output read as 0.
- R2: Offset 0x004 holds the device-type select in bit 8 (drives dev_type_o) and the core reset release in bit 0 (drives core_rst_rel_o, 1 = released). All other bits read 0.
- R3: Offset 0x008 holds the link-training enable in bit 0 (drives ltssm_en_o). It can be set and cleared by read-modify-write, and its other bits read 0.
- R4: Offset 0x028 is the interrupt enable register: bit 8 enables the MSI status bit and bits 7:0 enable the DMA channel status bits. Higher bits read 0.
- R5: Offset 0x02C is the interrupt status register, with MSI in bit 8 and DMA channel n in bit n. A bit is set by a rising edge of its event input. An input that stays high does not set the bit again after it has been cleared.
- R6: Writing 1 to a status bit clears it on that write. Writing 0 leaves the bit unchanged.
- R7: When a rising event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: irq_o is 1 exactly when some status bit and its enable bit are both 1.
- R9: Offset 0x0B0 reads the physical-layer link flag in bit 19 and the data-link-layer link flag in bit 8. link_up_o is 1 only when both flags are 1.
- R10: Offset 0x164 holds the PHY SRAM bypass in bit 8 (drives sram_byp_o). Offset 0x168 reads the PHY PLL lock in bit 1.
- R11: Offset 0x16C reads the reference PLL lock in bit 0. Offset 0x170 holds the PLL enable in bit 29 and the output enables in bits 24:21. Offset 0x178 holds the reference divider in bits 17:12 and the feedback divider in bits 11:0. Offset 0x17C holds post-divider A in bits 24:22 and post-divider B in bits 18:16. Each field drives its output.
- R12: Reads of unmapped offsets return 0 and writes to them change nothing. pready is always 1 and pslverr always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| msi_pend_i | input | 1 | MSI pending event from the controller |
| dma_evt_i | input | DMA_CH | DMA channel events |
| phy_link_i | input | 1 | Physical-layer link-up flag |
| dl_link_i | input | 1 | Data-link-layer link-up flag |
| mpll_lock_i | input | 1 | PHY PLL lock |
| rpll_lock_i | input | 1 | Reference PLL lock |
| core_rst_rel_o | output | 1 | Core reset release |
| dev_type_o | output | 1 | Device type select |
| ltssm_en_o | output | 1 | Link training enable |
| sram_byp_o | output | 1 | PHY SRAM bypass |
| rpll_en_o | output | 1 | Reference PLL enable |
| rpll_fout_en_o | output | 4 | PLL output enables |
| rpll_ref_div_o | output | 6 | PLL reference divider |
| rpll_fb_div_o | output | 12 | PLL feedback divider |
| rpll_pdiv_a_o | output | 3 | PLL post-divider A |
| rpll_pdiv_b_o | output | 3 | PLL post-divider B |
| link_up_o | output | 1 | Both link flags high |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: eight DMA channels and a 12-bit address. At these values the MSI status bit sits at bit 8, the position that software expects, and every mapped offset up to 0x17C can be reached. All nine status bits can be driven, so the bench can check the clear and set race on a DMA bit and on the MSI bit, and check masking across channels that are enabled and channels that are not. Unmapped offsets are probed both inside and above the mapped range.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int DATA_W = 32;

  localparam logic [11:0] OFF_CFG    = 12'h004;
  localparam logic [11:0] OFF_APP    = 12'h008;
  localparam logic [11:0] OFF_INTEN  = 12'h028;
  localparam logic [11:0] OFF_INTSTS = 12'h02C;
  localparam logic [11:0] OFF_LINK   = 12'h0B0;
  localparam logic [11:0] OFF_PHYCTL = 12'h164;
  localparam logic [11:0] OFF_PHYSTS = 12'h168;
  localparam logic [11:0] OFF_PLLSTS = 12'h16C;
  localparam logic [11:0] OFF_PLLEN  = 12'h170;
  localparam logic [11:0] OFF_PLLDIV = 12'h178;
  localparam logic [11:0] OFF_PLLPST = 12'h17C;

  typedef struct packed {
    logic        dev_type;
    logic        rst_rel;
    logic        ltssm_en;
    logic        sram_byp;
    logic        pll_en;
    logic [3:0]  fout_en;
    logic [5:0]  ref_div;
    logic [11:0] fb_div;
    logic [2:0]  pdiv_a;
    logic [2:0]  pdiv_b;
  } glue_ctl_t;
endpackage

// File: rtl/glue_evt_status.sv
module glue_evt_status #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] evt_q;
  logic [W-1:0] sts_q;
  logic [W-1:0] sts_d;
  logic [W-1:0] rise;

  assign rise = evt_i & ~evt_q;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_comb begin
        sts_d[i] = sts_q[i];
        if (clr_wr_i && clr_mask_i[i]) sts_d[i] = 1'b0;
        if (rise[i])                   sts_d[i] = 1'b1;
      end

      AST_CLEAR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_mask_i[i] && !(evt_i[i] && !evt_q[i])) |=> !sts_o[i]); // R6
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[i] && !evt_q[i]) |=> sts_o[i]); // R7
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(clr_wr_i && clr_mask_i[i]) && !(evt_i[i] && !evt_q[i])) |=> $stable(sts_o[i])); // R5
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      sts_q <= '0;
    end else begin
      evt_q <= evt_i;
      sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/glue_cfg_regs.sv
module glue_cfg_regs
  import glue_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int EN_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output glue_ctl_t         ctl_o,
  output logic [EN_W-1:0]   inten_o
);
  glue_ctl_t       ctl_q, ctl_d;
  logic [EN_W-1:0] inten_q, inten_d;

  logic hit_cfg, hit_app, hit_en, hit_phy, hit_pllen, hit_plldiv, hit_pllpst;
  assign hit_cfg    = wr_i && (addr_i == ADDR_W'(OFF_CFG));
  assign hit_app    = wr_i && (addr_i == ADDR_W'(OFF_APP));
  assign hit_en     = wr_i && (addr_i == ADDR_W'(OFF_INTEN));
  assign hit_phy    = wr_i && (addr_i == ADDR_W'(OFF_PHYCTL));
  assign hit_pllen  = wr_i && (addr_i == ADDR_W'(OFF_PLLEN));
  assign hit_plldiv = wr_i && (addr_i == ADDR_W'(OFF_PLLDIV));
  assign hit_pllpst = wr_i && (addr_i == ADDR_W'(OFF_PLLPST));

  logic wdata_unused;
  assign wdata_unused = ^{wdata_i[31:30], wdata_i[28:25], wdata_i[20:19]};

  always_comb begin
    ctl_d   = ctl_q;
    inten_d = inten_q;
    if (hit_cfg) begin
      ctl_d.dev_type = wdata_i[8];
      ctl_d.rst_rel  = wdata_i[0];
    end
    if (hit_app) ctl_d.ltssm_en = wdata_i[0];
    if (hit_en)  inten_d = wdata_i[EN_W-1:0];
    if (hit_phy) ctl_d.sram_byp = wdata_i[8];
    if (hit_pllen) begin
      ctl_d.pll_en  = wdata_i[29];
      ctl_d.fout_en = wdata_i[24:21];
    end
    if (hit_plldiv) begin
      ctl_d.ref_div = wdata_i[17:12];
      ctl_d.fb_div  = wdata_i[11:0];
    end
    if (hit_pllpst) begin
      ctl_d.pdiv_a = wdata_i[24:22];
      ctl_d.pdiv_b = wdata_i[18:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      inten_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      inten_q <= inten_d;
    end
  end

  assign ctl_o   = ctl_q;
  assign inten_o = inten_q;

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i != ADDR_W'(OFF_CFG) && addr_i != ADDR_W'(OFF_APP)
     && addr_i != ADDR_W'(OFF_INTEN) && addr_i != ADDR_W'(OFF_PHYCTL)
     && addr_i != ADDR_W'(OFF_PLLEN) && addr_i != ADDR_W'(OFF_PLLDIV)
     && addr_i != ADDR_W'(OFF_PLLPST)) |=> ($stable(ctl_o) && $stable(inten_o))); // R12
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(ctl_o) && $stable(inten_o))); // R1
endmodule

// File: rtl/pcie_glue_regs.sv
module pcie_glue_regs
  import glue_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DMA_CH = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              msi_pend_i,
  input  logic [DMA_CH-1:0] dma_evt_i,
  input  logic              phy_link_i,
  input  logic              dl_link_i,
  input  logic              mpll_lock_i,
  input  logic              rpll_lock_i,
  output logic              core_rst_rel_o,
  output logic              dev_type_o,
  output logic              ltssm_en_o,
  output logic              sram_byp_o,
  output logic              rpll_en_o,
  output logic [3:0]        rpll_fout_en_o,
  output logic [5:0]        rpll_ref_div_o,
  output logic [11:0]       rpll_fb_div_o,
  output logic [2:0]        rpll_pdiv_a_o,
  output logic [2:0]        rpll_pdiv_b_o,
  output logic              link_up_o,
  output logic              irq_o
);
  localparam int IRQ_W = DMA_CH + 1;

  glue_ctl_t        ctl;
  logic [IRQ_W-1:0] inten;
  logic [IRQ_W-1:0] sts;
  logic             wr_acc;
  logic             sts_clr;

  assign wr_acc  = psel && penable && pwrite;
  assign sts_clr = wr_acc && (paddr == ADDR_W'(OFF_INTSTS));

  glue_cfg_regs #(.ADDR_W(ADDR_W), .EN_W(IRQ_W)) u_cfg (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_i    (wr_acc),
    .addr_i  (paddr),
    .wdata_i (pwdata),
    .ctl_o   (ctl),
    .inten_o (inten)
  );

  glue_evt_status #(.W(IRQ_W)) u_sts (
    .clk        (pclk),
    .rst_n      (presetn),
    .evt_i      ({msi_pend_i, dma_evt_i}),
    .clr_wr_i   (sts_clr),
    .clr_mask_i (pwdata[IRQ_W-1:0]),
    .sts_o      (sts)
  );

  always_comb begin
    prdata = '0;
    unique case (paddr)
      ADDR_W'(OFF_CFG):    begin prdata[8] = ctl.dev_type; prdata[0] = ctl.rst_rel; end
      ADDR_W'(OFF_APP):    prdata[0] = ctl.ltssm_en;
      ADDR_W'(OFF_INTEN):  prdata[IRQ_W-1:0] = inten;
      ADDR_W'(OFF_INTSTS): prdata[IRQ_W-1:0] = sts;
      ADDR_W'(OFF_LINK):   begin prdata[19] = phy_link_i; prdata[8] = dl_link_i; end
      ADDR_W'(OFF_PHYCTL): prdata[8] = ctl.sram_byp;
      ADDR_W'(OFF_PHYSTS): prdata[1] = mpll_lock_i;
      ADDR_W'(OFF_PLLSTS): prdata[0] = rpll_lock_i;
      ADDR_W'(OFF_PLLEN):  begin prdata[29] = ctl.pll_en; prdata[24:21] = ctl.fout_en; end
      ADDR_W'(OFF_PLLDIV): begin prdata[17:12] = ctl.ref_div; prdata[11:0] = ctl.fb_div; end
      ADDR_W'(OFF_PLLPST): begin prdata[24:22] = ctl.pdiv_a; prdata[18:16] = ctl.pdiv_b; end
      default:             prdata = '0;
    endcase
  end

  assign pready         = 1'b1;
  assign pslverr        = 1'b0;
  assign core_rst_rel_o = ctl.rst_rel;
  assign dev_type_o     = ctl.dev_type;
  assign ltssm_en_o     = ctl.ltssm_en;
  assign sram_byp_o     = ctl.sram_byp;
  assign rpll_en_o      = ctl.pll_en;
  assign rpll_fout_en_o = ctl.fout_en;
  assign rpll_ref_div_o = ctl.ref_div;
  assign rpll_fb_div_o  = ctl.fb_div;
  assign rpll_pdiv_a_o  = ctl.pdiv_a;
  assign rpll_pdiv_b_o  = ctl.pdiv_b;
  assign link_up_o      = phy_link_i & dl_link_i;
  assign irq_o          = |(sts & inten);

  AST_IRQ_NEEDS_ENABLED_STATUS: assert property (@(posedge pclk) disable iff (!presetn)
    irq_o |-> (|sts && |inten)); // R8
  AST_LINK_NEEDS_BOTH: assert property (@(posedge pclk) disable iff (!presetn)
    link_up_o |-> (phy_link_i && dl_link_i)); // R9
endmodule

// File: tb/pcie_glue_regs_bench.sv
module pcie_glue_regs_bench;
  localparam int AW = 12;
  localparam int NCH = 8;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic msi_pend_i = 0;
  logic [NCH-1:0] dma_evt_i = '0;
  logic phy_link_i = 0, dl_link_i = 0, mpll_lock_i = 0, rpll_lock_i = 0;
  logic core_rst_rel_o, dev_type_o, ltssm_en_o, sram_byp_o, rpll_en_o;
  logic [3:0] rpll_fout_en_o;
  logic [5:0] rpll_ref_div_o;
  logic [11:0] rpll_fb_div_o;
  logic [2:0] rpll_pdiv_a_o, rpll_pdiv_b_o;
  logic link_up_o, irq_o;

  int checks = 0;
  int fails = 0;

  always #4 pclk = ~pclk;

  pcie_glue_regs #(.ADDR_W(AW), .DMA_CH(NCH)) u_pcie_glue_regs (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .pready, .pslverr, .msi_pend_i, .dma_evt_i, .phy_link_i, .dl_link_i,
    .mpll_lock_i, .rpll_lock_i, .core_rst_rel_o, .dev_type_o, .ltssm_en_o,
    .sram_byp_o, .rpll_en_o, .rpll_fout_en_o, .rpll_ref_div_o, .rpll_fb_div_o,
    .rpll_pdiv_a_o, .rpll_pdiv_b_o, .link_up_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 cfg", 12'h004, 0);
    rd_chk("R1 inten", 12'h028, 0);
    rd_chk("R1 status", 12'h02C, 0);
    rd_chk("R1 plldiv", 12'h178, 0);
    chk("R1 outputs", {core_rst_rel_o, dev_type_o, ltssm_en_o, sram_byp_o, rpll_en_o,
                       rpll_fout_en_o, rpll_ref_div_o, rpll_fb_div_o, irq_o}, 0);
  endtask

  task automatic t_cfg_app;
    logic [31:0] d;
    apb_wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R2 cfg readback", 12'h004, 32'h101);
    chk("R2 outputs", {dev_type_o, core_rst_rel_o}, 2'b11);
    apb_wr(12'h004, 32'h100);
    chk("R2 reset release low", core_rst_rel_o, 0);
    apb_wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R3 app readback", 12'h008, 1);
    chk("R3 ltssm on", ltssm_en_o, 1);
    apb_rd(12'h008, d);
    apb_wr(12'h008, d & ~32'h1);
    chk("R3 ltssm off by rmw", ltssm_en_o, 0);
  endtask

  task automatic t_phy_pll;
    apb_wr(12'h164, 32'hFFFF_FFFF);
    rd_chk("R10 phyctl", 12'h164, 32'h100);
    chk("R10 sram bypass", sram_byp_o, 1);
    mpll_lock_i = 1;
    rd_chk("R10 phy pll lock", 12'h168, 32'h2);
    rpll_lock_i = 1;
    rd_chk("R11 pll lock", 12'h16C, 32'h1);
    apb_wr(12'h170, 32'hFFFF_FFFF);
    rd_chk("R11 pll enable reg", 12'h170, 32'h21E0_0000);
    chk("R11 enable outs", {rpll_en_o, rpll_fout_en_o}, 5'h1F);
    apb_wr(12'h178, 32'hFFFF_FFFF);
    rd_chk("R11 div mask", 12'h178, 32'h0003_FFFF);
    apb_wr(12'h178, 32'h0000_5032);
    chk("R11 div outs", {rpll_ref_div_o, rpll_fb_div_o}, {6'd5, 12'h032});
    apb_wr(12'h17C, 32'hFFFF_FFFF);
    rd_chk("R11 post mask", 12'h17C, 32'h01C7_0000);
    apb_wr(12'h17C, 32'h0082_0000);
    chk("R11 post outs", {rpll_pdiv_a_o, rpll_pdiv_b_o}, 6'o22);
  endtask

  task automatic t_link;
    phy_link_i = 1; dl_link_i = 0;
    rd_chk("R9 phy only", 12'h0B0, 32'h0008_0000);
    chk("R9 link down", link_up_o, 0);
    phy_link_i = 0; dl_link_i = 1;
    #1 chk("R9 dl only", link_up_o, 0);
    phy_link_i = 1;
    rd_chk("R9 both", 12'h0B0, 32'h0008_0100);
    chk("R9 link up", link_up_o, 1);
  endtask

  task automatic t_status;
    apb_wr(12'h028, 32'hFFFF_FFFF);
    rd_chk("R4 inten mask", 12'h028, 32'h1FF);
    apb_wr(12'h028, 32'h0000_0008);
    @(negedge pclk) dma_evt_i[5] = 1;
    @(negedge pclk) dma_evt_i[5] = 0;
    rd_chk("R5 dma5 set", 12'h02C, 32'h20);
    chk("R8 masked no irq", irq_o, 0);
    @(negedge pclk) dma_evt_i[3] = 1;
    @(negedge pclk);
    chk("R8 enabled irq", irq_o, 1);
    apb_wr(12'h02C, 32'h0000_0000);
    rd_chk("R6 write zero keeps", 12'h02C, 32'h28);
    apb_wr(12'h02C, 32'h0000_0008);
    rd_chk("R5 held level no reset", 12'h02C, 32'h20);
    chk("R8 irq drops", irq_o, 0);
    dma_evt_i[3] = 0;
    apb_wr(12'h02C, 32'h0000_0020);
    rd_chk("R6 cleared", 12'h02C, 0);
  endtask

  task automatic t_race;
    @(negedge pclk) msi_pend_i = 1;
    @(negedge pclk) msi_pend_i = 0;
    rd_chk("R5 msi set", 12'h02C, 32'h100);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = 12'h02C; pwdata = 32'h102;
    @(negedge pclk);
    penable = 1; msi_pend_i = 1; dma_evt_i[1] = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0; msi_pend_i = 0; dma_evt_i[1] = 0;
    rd_chk("R7 set beats clear", 12'h02C, 32'h102);
    apb_wr(12'h028, 32'h100);
    #1 chk("R8 msi irq", irq_o, 1);
    apb_wr(12'h02C, 32'h1FF);
    #1 chk("R8 irq after clear", irq_o, 0);
  endtask

  task automatic t_unmapped;
    apb_wr(12'h00C, 32'hFFFF_FFFF);
    apb_wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped read", 12'h00C, 0);
    rd_chk("R12 high unmapped read", 12'h200, 0);
    rd_chk("R12 cfg untouched", 12'h004, 32'h100);
    rd_chk("R12 inten untouched", 12'h028, 32'h100);
    chk("R12 pready pslverr", {pready, pslverr}, 2'b10);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    t_reset();
    t_cfg_app();
    t_phy_pll();
    t_link();
    t_status();
    t_race();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule